// File: doc/BRIEF.md
# Boundary-Scan Octal Bus Transceiver

This block is an eight-channel bidirectional bus transceiver with a serial test port wrapped around it. In its ordinary role, an active-low enable and a direction input decide whether the A side drives the B side, the B side drives the A side, or neither drives. The bus pads are not modelled as tri-state wires. Each side is split into an input vector, an output vector and one output-enable bit.

A 16-state test-port controller runs on `tck` and is steered by `tms`. It gives serial access to three registers: an 8-bit instruction register, a 1-bit bypass register and a 36-bit boundary register. The boundary register has separate input and output cells for every bus pin, plus one cell each for the enable and direction pins. Test instructions can observe the pins, preload drive values, drive the pins from the boundary register, exercise the transceiver core from the register, float both sides, or hold the pins while the short bypass path is selected. Serial data is sampled on the rising edge of `tck`. `tdo` and every pin-level test effect change on the falling edge.

An undriven `tms` or `tdi` is meant to read as 1, so the integrating level must tie or pull these inputs high. With `tms` high the controller falls back to its reset state.

Top module: `bscan_xcvr8`

## Requirements
- R1: Under a non-intrusive instruction (BYPASS or SAMPLE), the pins follow the enable and direction inputs. With `oe_n`=0 and `dir`=1, `b_out`=`a_in` and only `b_oe` is 1. With `oe_n`=0 and `dir`=0, `a_out`=`b_in` and only `a_oe` is 1. With `oe_n`=1, both enables are 0.
- R2: The controller follows the standard 16-state diagram on the rising edge of `tck`. Five consecutive rising edges with `tms`=1 reach the reset state from any state. `rst_n` also forces the reset state.
- R3: In Capture-IR the instruction shifter loads 8'b10000001. The shifter shifts toward `tdo` LSB first. The active instruction changes only on the falling edge in Update-IR. In the reset state the active instruction is BYPASS.
- R4: Opcodes are BYPASS=8'hFF, EXTEST=8'h00, SAMPLE=8'h82, INTEST=8'h03, HIGHZ=8'h06 and CLAMP=8'h87. An opcode with an odd number of ones decodes as BYPASS. So does any other even-parity opcode.
- R5: The bypass register loads 0 in Capture-DR and then delays `tdi` by exactly one shift.
- R6: Boundary bit 35 is nearest `tdi` and bit 0 is shifted out first. Bit 35 is the enable cell and bit 34 the direction cell. Bits 33:26 are B input cells and 25:18 are B output cells. Bits 17:10 are A input cells and 9:2 are A output cells. Bits 1:0 are spares that capture 0. Input cells capture the pins. Output cells capture the core data: `a_in` for B and `b_in` for A, except under INTEST.
- R7: Scanning under SAMPLE or BYPASS leaves the pins in their R1 behaviour. A SAMPLE scan still loads the boundary update stage on the falling edge in Update-DR, which serves as a preload.
- R8: EXTEST drives `b_out` from update bits 25:18 and `a_out` from update bits 9:2. The enables come from the update enable cell (active low) and direction cell, using the R1 rules.
- R9: INTEST drives the pins as in EXTEST. The core then takes its inputs from the update input cells, so the B output cells capture update bits 17:10 and the A output cells capture update bits 33:26.
- R10: HIGHZ forces `a_oe` and `b_oe` to 0 and selects the bypass register.
- R11: CLAMP drives the pins from the update stage as in EXTEST and selects the bypass register.
- R12: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. Otherwise `tdo` is 0. `tdo` updates on the falling edge of `tck`.
- R13: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; also clocks every register in the block |
| rst_n | input | 1 | Asynchronous active-low reset, released on a `tck` rising edge |
| tms | input | 1 | Mode select for the test-port controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | High while serial data is being shifted out |
| oe_n | input | 1 | Transceiver enable, active low |
| dir | input | 1 | Direction: 1 drives B from A, 0 drives A from B |
| a_in | input | 8 | Values seen on the A-side pins |
| a_out | output | 8 | Values driven onto the A-side pins |
| a_oe | output | 1 | Drive enable for the A side |
| b_in | input | 8 | Values seen on the B-side pins |
| b_out | output | 8 | Values driven onto the B-side pins |
| b_oe | output | 1 | Drive enable for the B side |

## Verification
A controller that has lost its place shows up at `tdo_oe` on the next falling edge. It drops its enable or raises it in a state where it should stay quiet, so a miscounted shift is visible within one scan. A wrong instruction or a corrupt update stage appears at the pins on the falling edge that ends Update-IR or Update-DR: a wrong data byte, a wrong enable, or both sides enabled at once. A misrouted capture cell or a wrong cell order stays hidden until the next Capture-DR. It then appears as a bit at the wrong position in the serial stream, the same number of shifts after capture as its index.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int unsigned IR_W = 8;

  localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
  localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h82;
  localparam logic [IR_W-1:0] OP_INTEST  = 8'h03;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h06;
  localparam logic [IR_W-1:0] OP_CLAMP   = 8'h87;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h81;

  typedef enum logic [3:0] {
    ST_TLR,    ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    IN_BYPASS, IN_EXTEST, IN_SAMPLE, IN_INTEST, IN_HIGHZ, IN_CLAMP
  } instr_e;

  // Odd parity, or any opcode not in the table, falls back to bypass.
  function automatic instr_e decode_op(input logic [IR_W-1:0] op);
    instr_e res;
    res = IN_BYPASS;
    if (!(^op)) begin
      case (op)
        OP_EXTEST: res = IN_EXTEST;
        OP_SAMPLE: res = IN_SAMPLE;
        OP_INTEST: res = IN_INTEST;
        OP_HIGHZ:  res = IN_HIGHZ;
        OP_CLAMP:  res = IN_CLAMP;
        default:   res = IN_BYPASS;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q;
  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       sr_lsb,
  output instr_e     instr
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic [IR_W-1:0] act_q, act_d;
  logic            act_en;

  // Shifter, rising edge
  always_comb begin
    sr_en = (state == ST_CAP_IR) || (state == ST_SHF_IR);
    sr_d  = (state == ST_CAP_IR) ? IR_CAPTURE : {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= IR_CAPTURE;
    else if (sr_en) sr_q <= sr_d;
  end

  // Active instruction, falling edge
  always_comb begin
    act_en = (state == ST_TLR) || (state == ST_UPD_IR);
    act_d  = (state == ST_TLR) ? OP_BYPASS : sr_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      act_q <= OP_BYPASS;
    else if (act_en) act_q <= act_d;
  end

  assign sr_lsb = sr_q[0];
  assign instr  = decode_op(act_q);

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
  parameter int unsigned      W       = 36,
  parameter logic [W-1:0]     UPD_RST = '0
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         shf_en,
  input  logic         upd_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_vec,
  output logic         sr_lsb,
  output logic [W-1:0] upd_vec
);

  logic [W-1:0] sr_q, sr_d;
  logic [W-1:0] upd_q;

  // One capture/shift cell per bit; the top cell takes tdi.
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic shift_src;
    if (i == W-1) begin : g_top
      assign shift_src = tdi;
    end else begin : g_mid
      assign shift_src = sr_q[i+1];
    end
    assign sr_d[i] = cap_en ? cap_vec[i] : shift_src;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                 sr_q <= '0;
    else if (cap_en || shf_en)  sr_q <= sr_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      upd_q <= UPD_RST;
    else if (upd_en) upd_q <= sr_q;
  end

  assign sr_lsb  = sr_q[0];
  assign upd_vec = upd_q;

endmodule

// File: rtl/bscan_xcvr8.sv
module bscan_xcvr8
  import bscan_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned SPARE = 2
) (
  input  logic           tck,
  input  logic           rst_n,
  input  logic           tms,
  input  logic           tdi,
  output logic           tdo,
  output logic           tdo_oe,
  input  logic           oe_n,
  input  logic           dir,
  input  logic [NCH-1:0] a_in,
  output logic [NCH-1:0] a_out,
  output logic           a_oe,
  input  logic [NCH-1:0] b_in,
  output logic [NCH-1:0] b_out,
  output logic           b_oe
);

  localparam int unsigned BSR_W   = 2 + 4*NCH + SPARE;
  localparam int unsigned OE_IDX  = BSR_W - 1;
  localparam int unsigned DIR_IDX = BSR_W - 2;
  localparam int unsigned BI_HI   = BSR_W - 3;
  localparam int unsigned BI_LO   = BI_HI - NCH + 1;
  localparam int unsigned BO_HI   = BI_LO - 1;
  localparam int unsigned BO_LO   = BO_HI - NCH + 1;
  localparam int unsigned AI_HI   = BO_LO - 1;
  localparam int unsigned AI_LO   = AI_HI - NCH + 1;
  localparam int unsigned AO_HI   = AI_LO - 1;
  localparam int unsigned AO_LO   = AO_HI - NCH + 1;
  localparam logic [BSR_W-1:0] UPD_RST = {1'b1, {(BSR_W-1){1'b0}}};

  // Reset: asserted asynchronously, released on a rising edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  tap_state_e tap_state;
  instr_e     instr;
  logic       ir_lsb;

  bscan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_sync_n),
    .tms   (tms),
    .state (tap_state)
  );

  bscan_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_sync_n),
    .state  (tap_state),
    .tdi    (tdi),
    .sr_lsb (ir_lsb),
    .instr  (instr)
  );

  // Data register selection
  logic sel_bsr;
  assign sel_bsr = (instr == IN_EXTEST) || (instr == IN_SAMPLE) || (instr == IN_INTEST);

  // Bypass cell
  logic byp_q, byp_d, byp_en;
  always_comb begin
    byp_en = !sel_bsr && ((tap_state == ST_CAP_DR) || (tap_state == ST_SHF_DR));
    byp_d  = (tap_state == ST_CAP_DR) ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n)  byp_q <= 1'b0;
    else if (byp_en)  byp_q <= byp_d;
  end

  // Boundary register
  logic [BSR_W-1:0] cap_vec, upd_vec;
  logic             bsr_lsb;
  logic [NCH-1:0]   core_to_b, core_to_a;

  always_comb begin
    if (instr == IN_INTEST) begin
      core_to_b = upd_vec[AI_HI:AI_LO];
      core_to_a = upd_vec[BI_HI:BI_LO];
    end else begin
      core_to_b = a_in;
      core_to_a = b_in;
    end
    cap_vec                = '0;
    cap_vec[OE_IDX]        = oe_n;
    cap_vec[DIR_IDX]       = dir;
    cap_vec[BI_HI:BI_LO]   = b_in;
    cap_vec[BO_HI:BO_LO]   = core_to_b;
    cap_vec[AI_HI:AI_LO]   = a_in;
    cap_vec[AO_HI:AO_LO]   = core_to_a;
  end

  bscan_bsr #(
    .W       (BSR_W),
    .UPD_RST (UPD_RST)
  ) u_bsr (
    .tck     (tck),
    .rst_n   (rst_sync_n),
    .cap_en  (sel_bsr && (tap_state == ST_CAP_DR)),
    .shf_en  (sel_bsr && (tap_state == ST_SHF_DR)),
    .upd_en  (sel_bsr && (tap_state == ST_UPD_DR)),
    .tdi     (tdi),
    .cap_vec (cap_vec),
    .sr_lsb  (bsr_lsb),
    .upd_vec (upd_vec)
  );

  logic unused_spare;
  assign unused_spare = ^upd_vec[SPARE-1:0];

  // Pin steering
  always_comb begin
    case (instr)
      IN_EXTEST, IN_INTEST, IN_CLAMP, IN_HIGHZ: begin
        a_out = upd_vec[AO_HI:AO_LO];
        b_out = upd_vec[BO_HI:BO_LO];
        a_oe  = (instr != IN_HIGHZ) && !upd_vec[OE_IDX] && !upd_vec[DIR_IDX];
        b_oe  = (instr != IN_HIGHZ) && !upd_vec[OE_IDX] &&  upd_vec[DIR_IDX];
      end
      default: begin
        a_out = b_in;
        b_out = a_in;
        a_oe  = !oe_n && !dir;
        b_oe  = !oe_n &&  dir;
      end
    endcase
  end

  // Serial output, falling edge
  logic tdo_d, tdo_oe_d;
  always_comb begin
    tdo_oe_d = (tap_state == ST_SHF_IR) || (tap_state == ST_SHF_DR);
    if (tap_state == ST_SHF_IR)      tdo_d = ir_lsb;
    else if (tap_state == ST_SHF_DR) tdo_d = sel_bsr ? bsr_lsb : byp_q;
    else                             tdo_d = 1'b0;
  end

  always_ff @(negedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= tdo_oe_d;
    end
  end

endmodule

// File: rtl/bscan_xcvr8_chk.sv
module bscan_xcvr8_chk
  import bscan_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic           tck,
  input logic           rst_sync_n,
  input logic           tms,
  input tap_state_e     tap_state,
  input instr_e         instr,
  input logic           tdo,
  input logic           tdo_oe,
  input logic           oe_n,
  input logic           dir,
  input logic [NCH-1:0] a_in,
  input logic           a_oe,
  input logic [NCH-1:0] b_out,
  input logic           b_oe
);

  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n)            tms_run <= 3'd0;
    else if (!tms)              tms_run <= 3'd0;
    else if (tms_run != 3'd5)   tms_run <= tms_run + 3'd1;
  end

  p_tms_reset_r2: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (tms_run == 3'd5) |-> (tap_state == ST_TLR));

  p_reset_bypass_r3: assert property (@(posedge tck) disable iff (!rst_sync_n)
    ($past(tap_state) == ST_TLR && tap_state == ST_TLR) |-> (instr == IN_BYPASS));

  p_tdo_en_r12: assert property (@(posedge tck) disable iff (!rst_sync_n)
    tdo_oe == ((tap_state == ST_SHF_DR) || (tap_state == ST_SHF_IR)));

  p_tdo_quiet_r12: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !tdo_oe |-> !tdo);

  p_one_side_r13: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !(a_oe && b_oe));

  p_highz_r10: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (instr == IN_HIGHZ) |-> (!a_oe && !b_oe));

  p_normal_ab_r1: assert property (@(posedge tck) disable iff (!rst_sync_n)
    ((instr == IN_BYPASS || instr == IN_SAMPLE) && !oe_n && dir) |-> (b_oe && b_out == a_in));

  p_normal_off_r1: assert property (@(posedge tck) disable iff (!rst_sync_n)
    ((instr == IN_BYPASS || instr == IN_SAMPLE) && oe_n) |-> (!a_oe && !b_oe));

endmodule

bind bscan_xcvr8 bscan_xcvr8_chk #(.NCH(NCH)) u_chk (
  .tck        (tck),
  .rst_sync_n (rst_sync_n),
  .tms        (tms),
  .tap_state  (tap_state),
  .instr      (instr),
  .tdo        (tdo),
  .tdo_oe     (tdo_oe),
  .oe_n       (oe_n),
  .dir        (dir),
  .a_in       (a_in),
  .a_oe       (a_oe),
  .b_out      (b_out),
  .b_oe       (b_oe)
);

// File: tb/test_bscan_xcvr8.sv
module test_bscan_xcvr8;

  logic       tck;
  logic       rst_n;
  logic       tms;
  logic       tdi;
  logic       tdo;
  logic       tdo_oe;
  logic       oe_n;
  logic       dir;
  logic [7:0] a_in, a_out, b_in, b_out;
  logic       a_oe, b_oe;

  bscan_xcvr8 i_bscan_xcvr8 (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .oe_n(oe_n), .dir(dir), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  initial tck = 1'b0;
  always #4 tck = ~tck;   // 125 MHz

  int    n_chk  = 0;
  int    n_fail = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic  [35:0] upd_m;    // bench copy of the boundary update stage
  logic  mon_e;
  string mon_t;

  // Monitor: one expected bit per falling edge with tdo_oe high
  always @(negedge tck) begin
    #2;
    if (tdo_oe === 1'b1) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected shift bit: actual %b expected none", tdo);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        if (tdo !== mon_e) begin
          n_fail++;
          $display("FAIL %s tdo bit: actual %b expected %b", mon_t, tdo, mon_e);
        end
      end
    end
  end

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    @(negedge tck);
    tms = m;
    tdi = d;
  endtask

  task automatic settle();
    @(negedge tck);
    #2;
  endtask

  task automatic push_bits(input int n, input logic [63:0] v, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v[i]);
      tag_q.push_back(tag);
    end
  endtask

  // From Run-Test/Idle, load an opcode, back to Run-Test/Idle
  task automatic scan_ir(input logic [7:0] op);
    push_bits(8, 64'h81, "R3 instruction capture");
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < 8; i++) tick(i == 7, op[i]);
    tick(1, 1); tick(0, 1);
  endtask

  // From Run-Test/Idle, shift n data bits, back to Run-Test/Idle
  task automatic scan_dr(input int n, input logic [63:0] din,
                         input logic [63:0] dexp, input string tag);
    push_bits(n, dexp, tag);
    tick(1, 1); tick(0, 1); tick(0, 1);
    for (int i = 0; i < n; i++) tick(i == n-1, din[i]);
    tick(1, 1); tick(0, 1);
  endtask

  function automatic logic [35:0] bcells(input logic o, input logic d, input logic [7:0] bi,
                                         input logic [7:0] bo, input logic [7:0] ai,
                                         input logic [7:0] ao);
    return {o, d, bi, bo, ai, ao, 2'b00};
  endfunction

  function automatic logic [35:0] cap_exp(input logic intest);
    if (intest) return bcells(oe_n, dir, b_in, upd_m[17:10], a_in, upd_m[33:26]);
    return bcells(oe_n, dir, b_in, a_in, a_in, b_in);
  endfunction

  function automatic logic [63:0] byp_exp(input int n, input logic [63:0] d);
    return (d << 1) & ((64'd1 << n) - 64'd1);
  endfunction

  logic [35:0] pre1, pre2;

  initial begin
    rst_n = 1'b0; tms = 1'b1; tdi = 1'b1;
    oe_n = 1'b0; dir = 1'b1; a_in = 8'h5A; b_in = 8'h00;
    repeat (4) @(posedge tck);
    @(negedge tck) rst_n = 1'b1;
    repeat (3) @(posedge tck);
    settle();

    // Reset state
    check("R12 reset tdo/tdo_oe", {tdo, tdo_oe}, 2'b00);
    check("R1 reset A->B", {b_out, b_oe, a_oe}, {8'h5A, 2'b10});

    // Function table
    dir = 1'b0; b_in = 8'hC7; settle();
    check("R1 B->A", {a_out, a_oe, b_oe}, {8'hC7, 2'b10});
    oe_n = 1'b1; settle();
    check("R1 R13 isolation", {a_oe, b_oe}, 2'b00);

    // Controller walk to idle, then SAMPLE/preload
    tick(1, 1); tick(1, 1); tick(1, 1); tick(1, 1); tick(1, 1); tick(0, 1);
    oe_n = 1'b0; dir = 1'b1; a_in = 8'h96; b_in = 8'h3E;
    scan_ir(8'h82);
    settle();
    check("R7 pins after SAMPLE load", {b_out, b_oe, a_oe}, {8'h96, 2'b10});
    pre1 = bcells(1'b0, 1'b1, 8'hC3, 8'hA5, 8'h3C, 8'h5B);
    scan_dr(36, pre1, cap_exp(1'b0), "R6 R7 sample capture");
    upd_m = pre1;
    settle();
    check("R7 pins undisturbed by SAMPLE scan", {b_out, b_oe, a_oe}, {8'h96, 2'b10});

    // EXTEST drives preloaded values
    scan_ir(8'h00);
    settle();
    check("R8 EXTEST B drive", {b_out, b_oe, a_oe}, {8'hA5, 2'b10});
    a_in = 8'h01; settle();
    check("R8 EXTEST ignores a_in", b_out, 8'hA5);
    pre2 = bcells(1'b0, 1'b0, 8'hC3, 8'hA5, 8'h3C, 8'h5B);
    scan_dr(36, pre2, cap_exp(1'b0), "R6 R8 extest capture");
    upd_m = pre2;
    settle();
    check("R8 R13 EXTEST A drive", {a_out, a_oe, b_oe}, {8'h5B, 2'b10});

    // INTEST: core fed from update input cells
    scan_ir(8'h03);
    settle();
    check("R9 INTEST pins", {a_out, a_oe, b_oe}, {8'h5B, 2'b10});
    scan_dr(36, pre2, cap_exp(1'b1), "R9 intest capture");
    upd_m = pre2;

    // HIGHZ
    scan_ir(8'h06);
    settle();
    check("R10 HIGHZ enables", {a_oe, b_oe}, 2'b00);
    scan_dr(4, 64'hB, byp_exp(4, 64'hB), "R10 highz bypass path");

    // CLAMP
    scan_ir(8'h87);
    settle();
    check("R11 CLAMP pins", {a_out, a_oe, b_oe}, {8'h5B, 2'b10});
    scan_dr(4, 64'h6, byp_exp(4, 64'h6), "R11 clamp bypass path");

    // Bad parity and unlisted opcode
    scan_ir(8'h83);
    settle();
    check("R4 odd parity -> normal pins", {b_out, b_oe, a_oe}, {8'h01, 2'b10});
    scan_dr(5, 64'h15, byp_exp(5, 64'h15), "R4 odd parity bypass path");
    scan_ir(8'h05);
    settle();
    check("R4 unlisted opcode -> normal pins", {b_out, b_oe}, {8'h01, 1'b1});
    scan_dr(3, 64'h5, byp_exp(3, 64'h5), "R4 unlisted bypass path");

    // BYPASS
    scan_ir(8'hFF);
    scan_dr(8, 64'hD3, byp_exp(8, 64'hD3), "R5 bypass delay");
    settle();
    check("R12 idle tdo quiet", {tdo, tdo_oe}, 2'b00);

    // TMS-high reset from EXTEST
    scan_ir(8'h00);
    settle();
    check("R8 EXTEST before reset", {a_oe, b_oe}, 2'b10);
    tick(1, 1); tick(1, 1); tick(1, 1); tick(1, 1); tick(1, 1);
    settle();
    check("R2 R3 TMS reset -> normal pins", {b_out, b_oe, a_oe}, {8'h01, 2'b10});
    check("R12 tdo quiet in reset", {tdo, tdo_oe}, 2'b00);

    check("R12 all shift bits consumed", exp_q.size(), 0);
    finish_test();
  end

endmodule